// File: doc/BRIEF.md
# Pipelined Control Decode and Staging

This block sits beside the decode stage of a five-stage pipelined processor datapath. It decodes the 6-bit opcode of the instruction now in decode into nine control bits. It splits those bits into three groups: one for execute, one for memory access and one for write-back. The groups then ride down the pipeline one boundary per clock, in step with the instruction's data. At every boundary the group that the stage just used is discarded. The execute stage therefore sees three groups, the memory stage two, and the write-back stage only its own.

The surrounding datapath, ALU, register file and memories connect to the per-stage outputs. A hazard unit can raise `bubble` to inject a no-op. This zeroes every control bit that enters the first boundary, while instructions already further down keep moving. The fetch-side enables, for the program-counter write and the instruction read, carry no optional control and are tied high.

Top module: `ctl_pipe_stager`

## Requirements
- R1: While `rst` is high at a rising clock edge, every stage register is cleared. After that edge all execute, memory and write-back outputs are 0.
- R2: Opcode 6'h00 (register-register) drives the execute outputs `ex_dst_sel`=1, `ex_alu_mode`=2'b10 and `ex_imm_sel`=0. Its memory group is all 0, and its write-back group is `reg_wen`=1 with `load_sel`=0.
- R3: Opcode 6'h23 (load) decodes to `ex_dst_sel`=0, `ex_alu_mode`=2'b00 and `ex_imm_sel`=1. Its memory group has `rd_en`=1, and its write-back group is `reg_wen`=1 with `load_sel`=1.
- R4: Opcode 6'h2B (store) decodes to `ex_alu_mode`=2'b00, `ex_imm_sel`=1 and memory `wr_en`=1. Every other bit, including the destination select and the load select, is 0.
- R5: Opcode 6'h04 (branch-if-equal) decodes to `ex_alu_mode`=2'b01, `ex_imm_sel`=0 and memory `branch`=1. Every other bit is 0.
- R6: Any opcode other than 6'h00, 6'h23, 6'h2B or 6'h04 decodes to all nine control bits 0.
- R7: An opcode sampled at edge N drives the execute outputs after edge N, its memory group after edge N+1 and its write-back group after edge N+2. Execute bits are not carried past the execute boundary, and memory bits are not carried past the memory boundary.
- R8: When `bubble` is high at an edge, all nine bits entering the first boundary are 0. The memory and write-back groups of older instructions still advance that cycle.
- R9: At most one of `mem_branch`, `mem_rd_en` and `mem_wr_en` is high at any time.
- R10: `pc_wen` and `imem_ren` are 1 at all times, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bubble | input | 1 | Inject a no-op into the first boundary |
| id_opcode | input | 6 | Opcode field (instruction bits 31:26) in decode |
| pc_wen | output | 1 | Program-counter write enable (constant 1) |
| imem_ren | output | 1 | Instruction-memory read enable (constant 1) |
| ex_dst_sel | output | 1 | Execute: destination from rd field (1) or rt field (0) |
| ex_alu_mode | output | 2 | Execute: 00 add, 01 subtract, 10 use function field |
| ex_imm_sel | output | 1 | Execute: second ALU operand is the sign-extended immediate |
| mem_branch | output | 1 | Memory: branch-if-equal |
| mem_rd_en | output | 1 | Memory: data read |
| mem_wr_en | output | 1 | Memory: data write |
| wb_reg_wen | output | 1 | Write-back: register file write |
| wb_load_sel | output | 1 | Write-back: write data comes from memory, not the ALU |

## Verification
The bench sends back-to-back streams of mixed opcodes and checks every stage in every cycle. A design that skews one group by a cycle would pair a load's read enable with a neighbouring instruction's write-back bits. The bench fires a bubble between live instructions. Clearing more than the first boundary would wipe the memory or write-back bits of the older instructions. Unlisted opcodes such as 6'h08, 6'h02 and 6'h3F must decode to zeros, and a decoder that falls through to the register-register pattern would light up a register write. A reset in mid-stream catches a design that clears only the first boundary and leaves stale memory or write-back enables behind.

// File: rtl/ctl_stage_pkg.sv
package ctl_stage_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_REGREG = 6'h00;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE  = 6'h2B;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 6'h04;

    typedef enum logic [1:0] {
        ALU_ADD   = 2'b00,
        ALU_SUB   = 2'b01,
        ALU_FUNCT = 2'b10
    } alu_mode_e;

    typedef struct packed {
        logic      dst_sel;
        alu_mode_e alu_mode;
        logic      imm_sel;
    } ex_grp_t;

    typedef struct packed {
        logic branch;
        logic rd_en;
        logic wr_en;
    } mem_grp_t;

    typedef struct packed {
        logic reg_wen;
        logic load_sel;
    } wb_grp_t;

    // Full control word as it enters the first boundary
    typedef struct packed {
        ex_grp_t  ex;
        mem_grp_t mem;
        wb_grp_t  wb;
    } ctl_word_t;

    // What survives past the execute boundary
    typedef struct packed {
        mem_grp_t mem;
        wb_grp_t  wb;
    } ctl_post_ex_t;

    localparam int CTL_W     = $bits(ctl_word_t);
    localparam int POST_EX_W = $bits(ctl_post_ex_t);
    localparam int WB_W      = $bits(wb_grp_t);

    function automatic ctl_word_t decode_opcode(input logic [OPC_W-1:0] op);
        ctl_word_t c;
        c = '0;
        c.ex.alu_mode = ALU_ADD;
        unique case (op)
            OPC_REGREG: begin
                c.ex.dst_sel  = 1'b1;
                c.ex.alu_mode = ALU_FUNCT;
                c.wb.reg_wen  = 1'b1;
            end
            OPC_LOAD: begin
                c.ex.imm_sel  = 1'b1;
                c.mem.rd_en   = 1'b1;
                c.wb.reg_wen  = 1'b1;
                c.wb.load_sel = 1'b1;
            end
            OPC_STORE: begin
                c.ex.imm_sel  = 1'b1;
                c.mem.wr_en   = 1'b1;
            end
            OPC_BRANCH: begin
                c.ex.alu_mode = ALU_SUB;
                c.mem.branch  = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ctl_opcode_decoder.sv
module ctl_opcode_decoder
    import ctl_stage_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output ctl_word_t        ctl
);

    always_comb begin
        ctl = decode_opcode(opcode);
    end

endmodule

// File: rtl/ctl_stage_reg.sv
module ctl_stage_reg #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/ctl_pipe_stager.sv
module ctl_pipe_stager
    import ctl_stage_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bubble,
    input  logic [OPC_W-1:0] id_opcode,
    output logic             pc_wen,
    output logic             imem_ren,
    output logic             ex_dst_sel,
    output logic [1:0]       ex_alu_mode,
    output logic             ex_imm_sel,
    output logic             mem_branch,
    output logic             mem_rd_en,
    output logic             mem_wr_en,
    output logic             wb_reg_wen,
    output logic             wb_load_sel
);

    ctl_word_t    dec_ctl;
    ctl_word_t    id_ex_q;
    ctl_post_ex_t ex_mem_d;
    ctl_post_ex_t ex_mem_q;
    wb_grp_t      mem_wb_q;

    // Fetch side has no optional control
    assign pc_wen   = 1'b1;
    assign imem_ren = 1'b1;

    ctl_opcode_decoder u_dec (
        .opcode (id_opcode),
        .ctl    (dec_ctl)
    );

    // Decode -> execute boundary: full word, bubble clears it
    ctl_stage_reg #(.W(CTL_W)) u_id_ex (
        .clk   (clk),
        .rst   (rst),
        .clear (bubble),
        .d     (dec_ctl),
        .q     (id_ex_q)
    );

    // Execute -> memory boundary: execute group dropped
    assign ex_mem_d.mem = id_ex_q.mem;
    assign ex_mem_d.wb  = id_ex_q.wb;

    ctl_stage_reg #(.W(POST_EX_W)) u_ex_mem (
        .clk   (clk),
        .rst   (rst),
        .clear (1'b0),
        .d     (ex_mem_d),
        .q     (ex_mem_q)
    );

    // Memory -> write-back boundary: memory group dropped
    ctl_stage_reg #(.W(WB_W)) u_mem_wb (
        .clk   (clk),
        .rst   (rst),
        .clear (1'b0),
        .d     (ex_mem_q.wb),
        .q     (mem_wb_q)
    );

    assign ex_dst_sel  = id_ex_q.ex.dst_sel;
    assign ex_alu_mode = id_ex_q.ex.alu_mode;
    assign ex_imm_sel  = id_ex_q.ex.imm_sel;
    assign mem_branch  = ex_mem_q.mem.branch;
    assign mem_rd_en   = ex_mem_q.mem.rd_en;
    assign mem_wr_en   = ex_mem_q.mem.wr_en;
    assign wb_reg_wen  = mem_wb_q.reg_wen;
    assign wb_load_sel = mem_wb_q.load_sel;

endmodule

// File: rtl/ctl_pipe_stager_chk.sv
module ctl_pipe_stager_chk (
    input logic       clk,
    input logic       rst,
    input logic       bubble,
    input logic [5:0] id_opcode,
    input logic       ex_dst_sel,
    input logic [1:0] ex_alu_mode,
    input logic       ex_imm_sel,
    input logic       mem_branch,
    input logic       mem_rd_en,
    input logic       mem_wr_en,
    input logic       wb_reg_wen,
    input logic       wb_load_sel,
    input logic [2:0] idex_mem,
    input logic [1:0] exmem_wb
);

    AST_LOAD_DECODE: assert property (@(posedge clk) disable iff (rst)
        (id_opcode == 6'h23 && !bubble) |=> (!ex_dst_sel && ex_alu_mode == 2'b00 && ex_imm_sel)); // R3

    AST_STORE_DECODE: assert property (@(posedge clk) disable iff (rst)
        (id_opcode == 6'h2B && !bubble) |=> (!ex_dst_sel && ex_alu_mode == 2'b00 && ex_imm_sel)); // R4

    AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!bubble && id_opcode != 6'h00 && id_opcode != 6'h23 && id_opcode != 6'h2B && id_opcode != 6'h04)
        |=> (!ex_dst_sel && ex_alu_mode == 2'b00 && !ex_imm_sel)); // R6

    AST_MEM_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ({mem_branch, mem_rd_en, mem_wr_en} == $past(idex_mem))); // R7

    AST_WB_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ({wb_reg_wen, wb_load_sel} == $past(exmem_wb))); // R7

    AST_BUBBLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        bubble |=> (!ex_dst_sel && ex_alu_mode == 2'b00 && !ex_imm_sel && idex_mem == 3'b000)); // R8

    AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_branch, mem_rd_en, mem_wr_en})); // R9

endmodule

bind ctl_pipe_stager ctl_pipe_stager_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bubble      (bubble),
    .id_opcode   (id_opcode),
    .ex_dst_sel  (ex_dst_sel),
    .ex_alu_mode (ex_alu_mode),
    .ex_imm_sel  (ex_imm_sel),
    .mem_branch  (mem_branch),
    .mem_rd_en   (mem_rd_en),
    .mem_wr_en   (mem_wr_en),
    .wb_reg_wen  (wb_reg_wen),
    .wb_load_sel (wb_load_sel),
    .idex_mem    (id_ex_q.mem),
    .exmem_wb    (ex_mem_q.wb)
);

// File: tb/ctl_pipe_stager_test.sv
module ctl_pipe_stager_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bubble = 1'b0;
    logic [5:0] id_opcode = 6'h00;
    logic       pc_wen, imem_ren;
    logic       ex_dst_sel, ex_imm_sel;
    logic [1:0] ex_alu_mode;
    logic       mem_branch, mem_rd_en, mem_wr_en;
    logic       wb_reg_wen, wb_load_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Expected per-stage bits: [8]dst [7:6]alu [5]imm [4]br [3]rd [2]wr [1]regw [0]ldsel
    logic [8:0] exp_ex  = '0;
    logic [4:0] exp_mem = '0;
    logic [1:0] exp_wb  = '0;

    always #4 clk = ~clk;  // 125 MHz

    ctl_pipe_stager uut (
        .clk (clk), .rst (rst), .bubble (bubble), .id_opcode (id_opcode),
        .pc_wen (pc_wen), .imem_ren (imem_ren),
        .ex_dst_sel (ex_dst_sel), .ex_alu_mode (ex_alu_mode), .ex_imm_sel (ex_imm_sel),
        .mem_branch (mem_branch), .mem_rd_en (mem_rd_en), .mem_wr_en (mem_wr_en),
        .wb_reg_wen (wb_reg_wen), .wb_load_sel (wb_load_sel)
    );

    // Expected decode taken from the requirement table
    function automatic logic [8:0] table_ctl(input logic [5:0] op);
        case (op)
            6'h00:   return 9'b1_10_0_000_10;  // R2
            6'h23:   return 9'b0_00_1_010_11;  // R3
            6'h2B:   return 9'b0_00_1_001_00;  // R4
            6'h04:   return 9'b0_01_0_100_00;  // R5
            default: return 9'b0;              // R6
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "ex",    {5'b0, ex_dst_sel, ex_alu_mode, ex_imm_sel}, {5'b0, exp_ex[8:5]});
        check(req, "mem",   {6'b0, mem_branch, mem_rd_en, mem_wr_en},    {6'b0, exp_mem[4:2]});
        check(req, "wb",    {7'b0, wb_reg_wen, wb_load_sel},             {7'b0, exp_wb});
        check("R10", "fetch", {7'b0, pc_wen, imem_ren}, 9'b11);
    endtask

    // One clock: drive at falling edge, update model at rising edge, sample 1 ns later
    task automatic step(input logic [5:0] op, input logic bub, input logic r, input string req);
        @(negedge clk);
        id_opcode = op;
        bubble    = bub;
        rst       = r;
        @(posedge clk);
        if (r) begin
            exp_ex = '0; exp_mem = '0; exp_wb = '0;
        end else begin
            exp_wb  = exp_mem[1:0];
            exp_mem = exp_ex[4:0];
            exp_ex  = bub ? 9'b0 : table_ctl(op);
        end
        #1;
        check_all(req);
    endtask

    task automatic flush(input string req);
        for (int i = 0; i < 3; i++) step(6'h3F, 1'b0, 1'b0, req);
    endtask

    task automatic t_reset;  // R1
        step(6'h23, 1'b0, 1'b1, "R1");
        step(6'h00, 1'b0, 1'b1, "R1");
    endtask

    task automatic t_single(input logic [5:0] op, input string req);
        step(op, 1'b0, 1'b0, req);
        flush(req);
    endtask

    task automatic t_unknown;  // R6
        t_single(6'h08, "R6");
        t_single(6'h02, "R6");
        t_single(6'h3F, "R6");
        t_single(6'h24, "R6");
    endtask

    task automatic t_stream;  // R7, R9: back-to-back mixed opcodes
        step(6'h23, 1'b0, 1'b0, "R7");
        step(6'h2B, 1'b0, 1'b0, "R7");
        step(6'h04, 1'b0, 1'b0, "R7");
        step(6'h00, 1'b0, 1'b0, "R7");
        step(6'h23, 1'b0, 1'b0, "R9");
        step(6'h04, 1'b0, 1'b0, "R9");
        flush("R7");
    endtask

    task automatic t_bubble;  // R8
        step(6'h23, 1'b0, 1'b0, "R8");
        step(6'h00, 1'b0, 1'b0, "R8");
        step(6'h23, 1'b1, 1'b0, "R8");
        step(6'h2B, 1'b1, 1'b0, "R8");
        step(6'h00, 1'b0, 1'b0, "R8");
        flush("R8");
    endtask

    task automatic t_mid_reset;  // R1
        step(6'h23, 1'b0, 1'b0, "R1");
        step(6'h00, 1'b0, 1'b0, "R1");
        step(6'h2B, 1'b0, 1'b0, "R1");
        step(6'h04, 1'b0, 1'b1, "R1");
        step(6'h00, 1'b0, 1'b0, "R1");
        flush("R1");
    endtask

    initial begin
        t_reset();
        t_single(6'h00, "R2");
        t_single(6'h23, "R3");
        t_single(6'h2B, "R4");
        t_single(6'h04, "R5");
        t_unknown();
        t_stream();
        t_bubble();
        t_mid_reset();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule